// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Double Buffer

This block receives bytes over a two-wire synchronous serial link, one data line and one clock line. Incoming bits, least significant first, collect in a shift stage. Once a full byte has arrived it moves into a holding stage. The holding stage is offered to the host as a valid/ready output stream. The same cycle in which the byte becomes valid, the block raises a one-cycle interrupt pulse.

The block can act as clock master or as clock slave. As master, it drives the serial clock from a programmable divider of the system clock. The clock idles high and makes exactly one byte's worth of periods. As slave, it passes the external clock and data through a two-flop synchronizer and detects edges in the system clock domain. One configuration input selects whether bits are taken on rising or falling clock edges.

Flow control comes from the output handshake. While a byte waits unaccepted in the holding stage, no further bits are shifted. In master mode the clock stops. In slave mode external edges are ignored. Back-pressure is therefore lossless in master mode. In slave mode the sender must wait for the host. A receive-enable input gates the whole receive path. Dropping it in the middle of a byte discards the partial byte and leaves the holding stage alone.

Top module: `ser_rx_dbuf`

## Requirements
- R1: The first sampled bit of a byte appears at `m_data[0]` and the last at `m_data[DATA_W-1]`.
- R2: `m_valid` rises only after `DATA_W` bits have been sampled, never after fewer.
- R3: `irq` is high for exactly one cycle, the same cycle in which `m_valid` rises, and `m_valid` stays high until the handshake.
- R4: A cycle with `m_valid` and `m_ready` both high clears `m_valid` on the next cycle. While `m_valid` is high without `m_ready`, `m_data` holds steady.
- R5: While `m_valid` is high, nothing is shifted: in master mode `sclk_o` makes no transitions, and in slave mode external edges do not contribute to the next byte.
- R6: With `cfg_clk_out`=1, `sclk_oe` is 1 and `sclk_o` idles high. Each half period lasts `cfg_div`+1 system cycles, and a byte takes 2*`DATA_W` transitions, ending high.
- R7: With `cfg_clk_out`=0, `sclk_oe` is 0 and bits are taken from `rxd_i` on edges of `sclk_i` seen through a two-flop synchronizer.
- R8: `cfg_edge_fall`=0 samples on rising clock edges and `cfg_edge_fall`=1 samples on falling edges, in both clock modes.
- R9: With `cfg_rx_en`=0 no byte is received, and `sclk_o` is held high one cycle later.
- R10: Clearing `cfg_rx_en` mid-byte discards the partial byte, so the next byte is assembled from fresh bits. The held byte and `m_valid` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_clk_out | input | 1 | 1: block drives serial clock; 0: external clock |
| cfg_edge_fall | input | 1 | 0: sample on rising edge; 1: on falling edge |
| cfg_div | input | DIV_W | Half-period length minus one, in system cycles |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| rxd_i | input | 1 | Serial data in |
| m_valid | output | 1 | Held byte present (receive-complete flag) |
| m_ready | input | 1 | Host accepts the held byte |
| m_data | output | DATA_W | Held byte |
| irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The hardest state to reach is a stalled output with serial activity still arriving. The host holds off `m_ready` while an external clock keeps toggling, and the test must show that those edges leave no trace in the following byte. The bench sends a full byte into a stalled block, confirms that the held byte does not change, then accepts it and sends a different byte. Any stray bit would corrupt that byte. A similar sequence drops receive-enable after a few bits and then sends a fresh byte, so leftover bits would show up in the data.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Return the event matching the selected sampling edge.
  function automatic logic pick_edge(edge_sel_e sel, logic on_rise, logic on_fall);
    return (sel == EDGE_FALL) ? on_fall : on_rise;
  endfunction

endpackage

// File: rtl/ser_rx_sync.sv
// Two-flop synchronizer, one chain per bit.
module ser_rx_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[g] <= 1'b0;
        q[g]    <= 1'b0;
      end else begin
        meta[g] <= d[g];
        q[g]    <= meta[g];
      end
    end
  end

endmodule

// File: rtl/ser_rx_clkgen.sv
// Master-mode serial clock: idles high, makes 2*DATA_W transitions per byte.
module ser_rx_clkgen #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             tick_rise,
  output logic             tick_fall,
  output logic             done
);

  localparam int TOG_N = 2 * DATA_W;
  localparam int TW    = $clog2(TOG_N + 1);
  localparam logic [TW-1:0] TOG_LAST = TW'(TOG_N);

  logic [DIV_W-1:0] half_cnt;
  logic [TW-1:0]    tog_cnt;
  logic             at_edge;

  assign at_edge   = en && (tog_cnt < TOG_LAST) && (half_cnt == div);
  assign tick_rise = at_edge && !sclk;
  assign tick_fall = at_edge && sclk;
  assign done      = en && (tog_cnt == TOG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      tog_cnt  <= '0;
      sclk     <= 1'b1;
    end else if (!en) begin
      half_cnt <= '0;
      tog_cnt  <= '0;
      sclk     <= 1'b1;
    end else if (tog_cnt < TOG_LAST) begin
      if (at_edge) begin
        half_cnt <= '0;
        sclk     <= ~sclk;
        tog_cnt  <= tog_cnt + 1'b1;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ser_rx_shifter.sv
// First buffer: LSB-first shift stage with bit counter.
module ser_rx_shifter #(
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              din,
  input  logic              load_ok,
  output logic [DATA_W-1:0] word,
  output logic [CW-1:0]     cnt,
  output logic              load
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DATA_W);

  logic full;

  assign full = (cnt == FULL_CNT);
  assign load = full && load_ok && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr || load) begin
      cnt <= '0;
    end else if (sample && !full) begin
      word <= {din, word[DATA_W-1:1]};
      cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ser_rx_hold.sv
// Second buffer: holds the byte, presents it as a stream, pulses irq on fill.
module ser_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] dout,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= load;
      if (load) begin
        valid <= 1'b1;
        dout  <= din;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ser_rx_dbuf.sv
module ser_rx_dbuf
  import ser_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx_en,
  input  logic              cfg_clk_out,
  input  logic              cfg_edge_fall,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              rxd_i,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              irq
);

  localparam int CW = $clog2(DATA_W + 1);

  logic [1:0]        sync_q;
  logic              sclk_s, rxd_s, sclk_d;
  logic              ext_rise, ext_fall;
  logic              gen_en, gen_sclk, gen_rise, gen_fall, gen_done;
  logic              samp_int, samp_ext, sample_ev, sample_bit, load_ok;
  logic              load;
  logic [DATA_W-1:0] word;
  logic [CW-1:0]     shift_cnt;
  edge_sel_e         esel;

  ser_rx_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({sclk_i, rxd_i}),
    .q   (sync_q)
  );

  assign sclk_s = sync_q[1];
  assign rxd_s  = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign ext_rise = sclk_s && !sclk_d;
  assign ext_fall = !sclk_s && sclk_d;

  assign gen_en = cfg_rx_en && cfg_clk_out && !m_valid;

  ser_rx_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (gen_en),
    .div       (cfg_div),
    .sclk      (gen_sclk),
    .tick_rise (gen_rise),
    .tick_fall (gen_fall),
    .done      (gen_done)
  );

  assign sclk_o  = gen_sclk;
  assign sclk_oe = cfg_clk_out;

  assign esel       = edge_sel_e'(cfg_edge_fall);
  assign samp_int   = pick_edge(esel, gen_rise, gen_fall);
  assign samp_ext   = pick_edge(esel, ext_rise, ext_fall);
  assign sample_ev  = cfg_rx_en && !m_valid && (cfg_clk_out ? samp_int : samp_ext);
  assign sample_bit = cfg_clk_out ? rxd_i : rxd_s;
  assign load_ok    = !cfg_clk_out || gen_done;

  ser_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!cfg_rx_en),
    .sample  (sample_ev),
    .din     (sample_bit),
    .load_ok (load_ok),
    .word    (word),
    .cnt     (shift_cnt),
    .load    (load)
  );

  ser_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (word),
    .ready (m_ready),
    .valid (m_valid),
    .dout  (m_data),
    .irq   (irq)
  );

endmodule

// File: rtl/ser_rx_dbuf_chk.sv
module ser_rx_dbuf_chk #(
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rx_en,
  input logic              cfg_clk_out,
  input logic              sclk_o,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              irq,
  input logic [CW-1:0]     shift_cnt
);

  p_full_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(shift_cnt) == CW'(DATA_W));

  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> m_valid && $past(!m_valid));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  p_clear_on_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |=> !m_valid);

  p_clock_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_out && m_valid |-> sclk_o);

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx_en |=> sclk_o && shift_cnt == '0);

endmodule

bind ser_rx_dbuf ser_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rx_en   (cfg_rx_en),
  .cfg_clk_out (cfg_clk_out),
  .sclk_o      (sclk_o),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .irq         (irq),
  .shift_cnt   (shift_cnt)
);

// File: tb/tb_ser_rx_dbuf.sv
`timescale 1ns/1ps
module tb_ser_rx_dbuf;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, clk_out = 1'b0, edge_fall = 1'b0;
  logic [7:0] div = 8'd3;
  logic       sclk_i = 1'b0, rxd = 1'b0, ready = 1'b0;
  logic       sclk_o, sclk_oe, m_valid, irq;
  logic [7:0] m_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  ser_rx_dbuf dut (
    .clk (clk), .rst_n (rst_n), .cfg_rx_en (rx_en), .cfg_clk_out (clk_out),
    .cfg_edge_fall (edge_fall), .cfg_div (div), .sclk_i (sclk_i),
    .sclk_o (sclk_o), .sclk_oe (sclk_oe), .rxd_i (rxd), .m_valid (m_valid),
    .m_ready (ready), .m_data (m_data), .irq (irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Accept the held byte and confirm it and the flag clear.
  task automatic take_byte(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(m_valid == 1'b1, {req, " valid before take"}, m_valid, 1);
    chk(m_data == exp, {req, " data"}, m_data, exp);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(m_valid == 1'b0, "R4 valid cleared by handshake", m_valid, 0);
  endtask

  task automatic slave_bit(input logic b);
    sclk_i = edge_fall;
    rxd = b;
    idle(H);
    sclk_i = ~edge_fall;
    idle(H);
    sclk_i = edge_fall;
  endtask

  task automatic slave_byte(input logic [7:0] d, input bit check_partial);
    for (int i = 0; i < 8; i++) begin
      slave_bit(d[i]);
      if (check_partial && i == 6)
        chk(m_valid == 1'b0, "R2 no valid after 7 bits", m_valid, 0);
    end
    idle(6);
  endtask

  task automatic set_slave(input bit fall);
    clk_out = 1'b0; edge_fall = fall; sclk_i = fall;
    idle(6);
  endtask

  task automatic t_reset();
    chk(m_valid == 1'b0, "R3 reset valid", m_valid, 0);
    chk(irq == 1'b0, "R3 reset irq", irq, 0);
    chk(m_data == 8'h00, "R4 reset data", m_data, 0);
    chk(sclk_o == 1'b1, "R6 reset clock high", sclk_o, 1);
    chk(sclk_oe == 1'b0, "R7 slave oe low", sclk_oe, 0);
  endtask

  task automatic t_master(input logic [7:0] d, input bit fall);
    int toggles = 0, nf = 0, nr = 0, last = 0, irqs = 0;
    logic prev;
    clk_out = 1'b1; edge_fall = fall; rxd = d[0];
    @(negedge clk);
    chk(sclk_oe == 1'b1, "R6 master oe", sclk_oe, 1);
    rx_en = 1'b1;
    prev = sclk_o;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (m_valid) break;
      if (irq) irqs++;
      if (sclk_o != prev) begin
        toggles++;
        if (toggles == 2) chk(i - last == int'(div) + 1, "R6 half period", i - last, div + 1);
        last = i;
        if (!fall && !sclk_o) begin rxd = d[nf]; nf++; end
        if (fall && sclk_o) begin if (nr < 7) rxd = d[nr + 1]; nr++; end
        prev = sclk_o;
      end
    end
    chk(m_valid == 1'b1, "R2 master byte arrived", m_valid, 1);
    chk(irq == 1'b1 && irqs == 0, "R3 irq with valid", irq, 1);
    chk(toggles == 16, "R6 transitions per byte", toggles, 16);
    chk(sclk_o == 1'b1, "R6 ends high", sclk_o, 1);
    chk(m_data == d, fall ? "R8 falling master data R1" : "R8 rising master data R1", m_data, d);
    @(negedge clk);
    chk(irq == 1'b0 && m_valid, "R3 irq one cycle", irq, 0);
    toggles = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk_o != 1'b1) toggles++;
    end
    chk(toggles == 0, "R5 clock stopped while held", toggles, 0);
    rx_en = 1'b0;
    idle(2);
    chk(m_valid == 1'b1 && m_data == d, "R10 disable keeps held byte", m_data, d);
    take_byte(d, "R1");
  endtask

  task automatic t_slave(input logic [7:0] d, input bit fall);
    set_slave(fall);
    rx_en = 1'b1;
    slave_byte(d, 1'b1);
    chk(sclk_oe == 1'b0, "R7 oe low in slave", sclk_oe, 0);
    chk(m_data == d, fall ? "R8 falling slave R7" : "R8 rising slave R7", m_data, d);
    take_byte(d, "R1");
    rx_en = 1'b0;
    idle(2);
  endtask

  task automatic t_disabled();
    int toggles = 0;
    set_slave(1'b0);
    rx_en = 1'b0;
    slave_byte(8'hFF, 1'b0);
    chk(m_valid == 1'b0, "R9 no byte when disabled", m_valid, 0);
    clk_out = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk_o != 1'b1) toggles++;
    end
    chk(toggles == 0, "R9 master clock parked", toggles, 0);
  endtask

  task automatic t_abort();
    set_slave(1'b0);
    rx_en = 1'b1;
    for (int i = 0; i < 4; i++) slave_bit(1'b1);
    idle(4);
    rx_en = 1'b0;
    idle(3);
    rx_en = 1'b1;
    slave_byte(8'h96, 1'b0);
    chk(m_data == 8'h96, "R10 partial byte discarded", m_data, 8'h96);
    take_byte(8'h96, "R10");
    rx_en = 1'b0;
    clk_out = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    idle(int'(div) * 3 + 6);
    rx_en = 1'b0;
    idle(2);
    chk(sclk_o == 1'b1, "R9 master abort parks clock", sclk_o, 1);
    t_master(8'h81, 1'b0);
  endtask

  task automatic t_backpressure();
    set_slave(1'b0);
    rx_en = 1'b1;
    slave_byte(8'h11, 1'b0);
    chk(m_valid == 1'b1, "R3 first byte held", m_valid, 1);
    slave_byte(8'hEE, 1'b0);
    chk(m_valid == 1'b1 && m_data == 8'h11, "R5 edges ignored while held R4", m_data, 8'h11);
    take_byte(8'h11, "R4");
    slave_byte(8'h77, 1'b0);
    chk(m_data == 8'h77, "R5 next byte clean", m_data, 8'h77);
    take_byte(8'h77, "R5");
    rx_en = 1'b0;
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_master(8'hA5, 1'b0);
    t_master(8'h3C, 1'b1);
    t_slave(8'h5A, 1'b0);
    t_slave(8'hC3, 1'b1);
    t_disabled();
    t_abort();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule